// File: doc/BRIEF.md
# Mixed-Sign Multiplier

This block takes two 16-bit operands and returns their 32-bit product one clock after a valid input. A 2-bit mode input marks each operand as signed or unsigned on its own. That gives four cases: signed by signed, unsigned by unsigned, signed by unsigned, and unsigned by signed.

Each operand is widened to 17 bits according to its mode. A signed operand copies bit 15 into bit 16. An unsigned operand gets a zero in bit 16. Both widened values then go into one signed 17x17 array. The low 32 bits of the 34-bit signed result are the product, and they are registered together with a valid flag.

Top module: `mixmul`

## Requirements
- R1: After reset, `prod_vld` is 0 and `prod` is 0.
- R2: When `in_vld` is 1 at a rising clock edge, `prod_vld` is 1 in the following cycle. When `in_vld` is 0, `prod_vld` is 0 in the following cycle.
- R3: Bit 0 of `sgn_mode` selects how `a` is read: 1 means two's complement signed, 0 means unsigned. Bit 1 of `sgn_mode` does the same for `b`.
- R4: With both mode bits 0, `prod` equals the unsigned product of `a` and `b`. For example, 0xFFFF × 0xFFFF gives 0xFFFE0001.
- R5: With both mode bits 1, `prod` equals the signed 32-bit product. For example, 0x8000 × 0x8000 gives 0x40000000.
- R6: With mixed modes, `prod` equals the signed product of the signed operand and the unsigned operand, as a 32-bit two's complement value. For example, `a`=0xFFFF unsigned times `b`=0xFFFF signed gives 0xFFFF0001.
- R7: When `in_vld` is 0 at a clock edge, `prod` holds its previous value.
- R8: Back-to-back valid inputs give one result per cycle, each appearing exactly one cycle after its input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operands valid |
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| sgn_mode | input | 2 | Bit 0: `a` signed; bit 1: `b` signed |
| prod_vld | output | 1 | Product valid |
| prod | output | 32 | Registered 32-bit product |

## Verification
Assertions check every cycle that the valid flag follows the previous cycle's input valid, and that the product holds when no input was accepted. They also check three sign properties:
- A product from two unsigned operands never goes negative once taken to 34 bits.
- A zero operand always gives a zero product.
- In the signed-by-signed case, the result has the sign predicted by the operand signs.

Correct arithmetic values for each mode can only be shown by the bench's sweeps. These cover walking-bit and boundary operands in all four modes, including the three extreme corner products.

// File: rtl/mixmul.sv
module mixmul #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [1:0]     sgn_mode,
  output logic           prod_vld,
  output logic [2*W-1:0] prod
);
  localparam int XW = W + 1;
  localparam int PW = 2 * XW;

  logic signed [XW-1:0] a_x, b_x;
  logic signed [PW-1:0] full;

  assign a_x  = {sgn_mode[0] & a[W-1], a};
  assign b_x  = {sgn_mode[1] & b[W-1], b};
  assign full = a_x * b_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_vld <= 1'b0;
      prod     <= '0;
    end else begin
      prod_vld <= in_vld;
      if (in_vld) prod <= full[2*W-1:0];
    end
  end

  // R2
  a_r2_vld_follows: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld == $past(in_vld));
  // R7
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(prod));
  // R4: unsigned products are never negative at full width
  a_r4_unsigned_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sgn_mode == 2'b00) |-> !full[PW-1]);
  // R3: zero operand yields zero product
  a_r3_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (a == '0 || b == '0)) |=> prod == '0);
  // R5: sign of signed-signed product
  a_r5_sign: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && sgn_mode == 2'b11 && a != '0 && b != '0)
      |-> full[PW-1] == (a[W-1] ^ b[W-1]));
endmodule

// File: tb/mixmul_tb.sv
module mixmul_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_vld = 0;
  logic [15:0] a = 0, b = 0;
  logic [1:0]  sgn_mode = 0;
  logic        prod_vld;
  logic [31:0] prod;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mixmul dut_i (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a(a), .b(b),
                .sgn_mode(sgn_mode), .prod_vld(prod_vld), .prod(prod));

  function automatic logic [31:0] expect_of(logic [15:0] x, logic [15:0] y, logic [1:0] m);
    longint xv, yv;
    xv = m[0] ? longint'($signed(x)) : longint'(x);
    yv = m[1] ? longint'($signed(y)) : longint'(y);
    return 32'(xv * yv);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] x, logic [15:0] y, logic [1:0] m);
    @(negedge clk);
    in_vld = v; a = x; b = y; sgn_mode = m;
  endtask

  function automatic string req_of(logic [1:0] m);
    return (m == 2'b00) ? "R4" : (m == 2'b11) ? "R5" : "R6";
  endfunction

  // one result per cycle, checked one cycle after issue (R8)
  task automatic run_pair(logic [15:0] x, logic [15:0] y, logic [1:0] m);
    drive(1, x, y, m);
    @(negedge clk);
    check("R8", {31'b0, prod_vld}, 32'd1);
  endtask

  initial begin
    logic [15:0] pats[10];
    logic [31:0] held;
    pats = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'h8001,
             16'hFFFF, 16'h00FF, 16'hFF00, 16'h5555, 16'hAAAA};
    #12;
    check("R1", {31'b0, prod_vld}, 0);
    check("R1", prod, 0);
    rst_n = 1;
    // corners
    drive(1, 16'h8000, 16'h8000, 2'b11);
    @(negedge clk); check("R5", prod, 32'h40000000);
    drive(1, 16'hFFFF, 16'hFFFF, 2'b00);
    @(negedge clk); check("R4", prod, 32'hFFFE0001);
    drive(1, 16'hFFFF, 16'hFFFF, 2'b10);
    @(negedge clk); check("R6", prod, 32'hFFFF0001);
    drive(1, 16'hFFFF, 16'h0002, 2'b01);
    @(negedge clk); check("R3", prod, 32'hFFFFFFFE);
    // hold and valid drop
    held = prod;
    drive(0, 16'h1234, 16'h5678, 2'b00);
    @(negedge clk);
    check("R2", {31'b0, prod_vld}, 0);
    check("R7", prod, held);
    // pattern sweep, back-to-back
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 10; i++)
        for (int j = 0; j < 10; j++) begin
          drive(1, pats[i], pats[j], 2'(m));
          @(posedge clk); #1;
          check(req_of(2'(m)), prod, expect_of(pats[i], pats[j], 2'(m)));
          check("R2", {31'b0, prod_vld}, 1);
        end
    // walking bits across modes
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 16; i++)
        for (int j = 0; j < 16; j++) begin
          drive(1, 16'(1) << i, ~(16'(1) << j), 2'(m));
          @(posedge clk); #1;
          check(req_of(2'(m)), prod, expect_of(16'(1) << i, ~(16'(1) << j), 2'(m)));
        end
    run_pair(16'h0003, 16'hFFFD, 2'b11);
    check("R5", prod, 32'hFFFFFFF7);
    drive(0, 0, 0, 0);
    @(negedge clk);
    check("R2", {31'b0, prod_vld}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule